// File: doc/BRIEF.md
# Real-Time Clock Alarm Matcher

This block keeps four alarm bytes (seconds, minutes, hours, date) and compares them with the current BCD time supplied by a separate time counter. When the comparison succeeds on a once-per-second tick, it emits a single-cycle interrupt pulse. Bit 7 of each alarm byte is a mask bit. Together the four mask bits choose how often the alarm repeats: once a month, once a day, once an hour, once a minute or every second.

The host loads alarm bytes through a simple write port. A range check on the BCD value rejects bad writes. The host reads the stored bytes back through a combinational read port. A run input from the time counter suppresses alarms while the clock is stopped.

Top module: `rtc_alarm_match`

## Requirements
- R1: Alarm bytes sit at write/read address 0 (seconds), 1 (minutes), 2 (hours) and 3 (date). An accepted write stores the full byte, mask bit 7 included, and the read port returns it combinationally in the cycle after the write edge.
- R2: A seconds write is ignored when its bits 6:0, read as BCD (tens = bits 6:4, units = bits 3:0, value = tens*10+units), exceed 59.
- R3: A minutes write follows the same rule as R2: it is ignored when the bits 6:0 value exceeds 59.
- R4: An hours write is ignored when the BCD value of bits 5:0 (tens = bits 5:4) exceeds 23.
- R5: A date write is ignored unless the BCD value of bits 4:0 (tens = bit 4) lies in 1..31.
- R6: With no mask bit set, the alarm fires when seconds and minutes (bits 6:0) and hours and date (bits 5:0) all equal the current time.
- R7: With only the date mask set, the alarm fires when hours, minutes and seconds match.
- R8: With only the date and hours masks set, the alarm fires when minutes and seconds match.
- R9: With the date, hours and minutes masks set and the seconds mask clear, the alarm fires when seconds match.
- R10: Every other mask combination, all four set included, fires on every tick.
- R11: Matching is evaluated only on a tick cycle. The pulse is high for exactly the one cycle after that tick edge and is never raised without a tick.
- R12: While the run input is low, no alarm fires.
- R13: After reset all alarm bytes read 0x00 and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe once per second |
| clkRun | input | 1 | High while the time counter runs |
| curSec | input | 8 | Current seconds, BCD |
| curMin | input | 8 | Current minutes, BCD |
| curHour | input | 8 | Current hours, BCD |
| curDate | input | 8 | Current date, BCD |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 2 | Write register select |
| wrData | input | 8 | Write data |
| rdAddr | input | 2 | Read register select |
| rdData | output | 8 | Read data, combinational |
| alarmIrq | output | 1 | Alarm interrupt pulse |

## Verification
A write is stored on the edge that samples it, so the bench drives writes at the falling edge and reads back at the next falling edge. The interrupt is registered from the tick cycle. The bench raises tick at a falling edge and expects the pulse at the following falling edge. It then expects the pulse to be low one cycle later, which checks the pulse width. Tests that check an ignored write read the register back before any other write, and tests that check a suppressed alarm watch the interrupt over several idle cycles.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int FIELDS = 4;
  localparam int DATA_W = 8;
  localparam int ADDR_W = $clog2(FIELDS);

  typedef enum logic [ADDR_W-1:0] {FLD_SEC, FLD_MIN, FLD_HOUR, FLD_DATE} fieldE;
  typedef enum logic [2:0] {RPT_MONTH, RPT_DAY, RPT_HOUR, RPT_MIN, RPT_SEC} repeatE;

  typedef struct packed {
    logic [FIELDS-1:0] wrSel;
    logic              evalEn;
  } ctrlStrobeT;

  function automatic logic [7:0] bcdToBin(input logic [3:0] tens, input logic [3:0] units);
    return (8'(tens) * 8'd10) + 8'(units);
  endfunction
endpackage

// File: rtl/alarm_ctrl.sv
module alarm_ctrl
  import alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              clkRun,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output ctrlStrobeT        strb
);
  logic       inRange;
  logic [7:0] binVal;

  always_comb begin
    binVal  = 8'd0;
    inRange = 1'b0;
    unique case (fieldE'(wrAddr))
      FLD_SEC, FLD_MIN: begin
        binVal  = bcdToBin({1'b0, wrData[6:4]}, wrData[3:0]);
        inRange = (binVal <= 8'd59);
      end
      FLD_HOUR: begin
        binVal  = bcdToBin({2'b0, wrData[5:4]}, wrData[3:0]);
        inRange = (binVal <= 8'd23);
      end
      FLD_DATE: begin
        binVal  = bcdToBin({3'b0, wrData[4]}, wrData[3:0]);
        inRange = (binVal >= 8'd1) && (binVal <= 8'd31);
      end
      default: inRange = 1'b0;
    endcase
  end

  always_comb begin
    strb.wrSel  = '0;
    if (wrEn && inRange) strb.wrSel[wrAddr] = 1'b1;
    strb.evalEn = tick & clkRun;
  end

  // R1
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.wrSel));

  // R11
  eval_needs_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.evalEn |-> tick);
endmodule

// File: rtl/alarm_dp.sv
module alarm_dp
  import alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] curSec,
  input  logic [DATA_W-1:0] curMin,
  input  logic [DATA_W-1:0] curHour,
  input  logic [DATA_W-1:0] curDate,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              alarmIrq
);
  logic [DATA_W-1:0] alarmReg [FIELDS];
  logic [FIELDS-1:0] maskBits;
  logic              secHit, minHit, hourHit, dateHit;
  logic              fire;
  repeatE            rptMode;

  for (genvar f = 0; f < FIELDS; f++) begin : g_field
    always_ff @(posedge clk) begin
      if (!rstN)               alarmReg[f] <= '0;
      else if (strb.wrSel[f])  alarmReg[f] <= wrData;
    end
    assign maskBits[f] = alarmReg[f][DATA_W-1];

    // R2
    hold_unselected_chk: assert property (@(posedge clk) disable iff (!rstN)
      !strb.wrSel[f] |=> $stable(alarmReg[f]));
  end

  assign secHit  = alarmReg[FLD_SEC][6:0]  == curSec[6:0];
  assign minHit  = alarmReg[FLD_MIN][6:0]  == curMin[6:0];
  assign hourHit = alarmReg[FLD_HOUR][5:0] == curHour[5:0];
  assign dateHit = alarmReg[FLD_DATE][5:0] == curDate[5:0];

  always_comb begin
    unique case (maskBits)
      4'b0000: rptMode = RPT_MONTH;
      4'b1000: rptMode = RPT_DAY;
      4'b1100: rptMode = RPT_HOUR;
      4'b1110: rptMode = RPT_MIN;
      default: rptMode = RPT_SEC;
    endcase
  end

  always_comb begin
    unique case (rptMode)
      RPT_MONTH: fire = dateHit & hourHit & minHit & secHit;
      RPT_DAY:   fire = hourHit & minHit & secHit;
      RPT_HOUR:  fire = minHit & secHit;
      RPT_MIN:   fire = secHit;
      default:   fire = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) alarmIrq <= 1'b0;
    else       alarmIrq <= strb.evalEn & fire;
  end

  assign rdData = alarmReg[rdAddr];

  // R11
  irq_from_eval_chk: assert property (@(posedge clk) disable iff (!rstN)
    alarmIrq |-> $past(strb.evalEn));
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import alarm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       clkRun,
  input  logic [7:0] curSec,
  input  logic [7:0] curMin,
  input  logic [7:0] curHour,
  input  logic [7:0] curDate,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic [1:0] rdAddr,
  output logic [7:0] rdData,
  output logic       alarmIrq
);
  ctrlStrobeT strb;

  alarm_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .clkRun(clkRun),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .strb(strb)
  );

  alarm_dp i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .curSec(curSec), .curMin(curMin), .curHour(curHour), .curDate(curDate),
    .rdAddr(rdAddr), .rdData(rdData), .alarmIrq(alarmIrq)
  );

  // R12
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clkRun |=> !alarmIrq);
endmodule

// File: tb/test_rtc_alarm_match.sv
module test_rtc_alarm_match;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  logic clk = 0, rstN = 0, tick = 0, clkRun = 1, wrEn = 0;
  logic [7:0] curSec = 0, curMin = 0, curHour = 0, curDate = 0, wrData = 0, rdData;
  logic [1:0] wrAddr = 0, rdAddr = 0;
  logic alarmIrq;
  int nChecks = 0, nFails = 0;

  // fields: alarm sec,min,hour,date | current sec,min,hour,date | expected irq | req number
  localparam logic [76:0] VEC [NVEC] = '{
    {8'h56,8'h34,8'h12,8'h15, 8'h56,8'h34,8'h12,8'h15, 1'b1, 12'd6},  // R6 full match
    {8'h56,8'h34,8'h12,8'h15, 8'h56,8'h34,8'h12,8'h16, 1'b0, 12'd6},  // R6 date differs
    {8'h56,8'h34,8'h12,8'h95, 8'h56,8'h34,8'h12,8'h16, 1'b1, 12'd7},  // R7 date ignored
    {8'h56,8'h34,8'h12,8'h95, 8'h56,8'h34,8'h13,8'h15, 1'b0, 12'd7},  // R7 hour differs
    {8'h56,8'h34,8'h92,8'h95, 8'h56,8'h34,8'h13,8'h16, 1'b1, 12'd8},  // R8 hour ignored
    {8'h56,8'h34,8'h92,8'h95, 8'h56,8'h35,8'h12,8'h15, 1'b0, 12'd8},  // R8 minute differs
    {8'h56,8'hB4,8'h92,8'h95, 8'h56,8'h35,8'h13,8'h16, 1'b1, 12'd9},  // R9 minute ignored
    {8'h56,8'hB4,8'h92,8'h95, 8'h57,8'h34,8'h12,8'h15, 1'b0, 12'd9},  // R9 second differs
    {8'hD6,8'hB4,8'h92,8'h95, 8'h01,8'h02,8'h03,8'h04, 1'b1, 12'd10}, // R10 all masks
    {8'hD6,8'h34,8'h12,8'h15, 8'h01,8'h02,8'h03,8'h04, 1'b1, 12'd10}, // R10 seconds mask only
    {8'h56,8'h34,8'h92,8'h15, 8'h01,8'h02,8'h03,8'h04, 1'b1, 12'd10}, // R10 hours mask only
    {8'h56,8'h34,8'h52,8'h15, 8'h56,8'h34,8'h12,8'h15, 1'b1, 12'd6}   // R6 hour bit 6 not compared
  };

  rtc_alarm_match i_rtc_alarm_match (
    .clk(clk), .rstN(rstN), .tick(tick), .clkRun(clkRun),
    .curSec(curSec), .curMin(curMin), .curHour(curHour), .curDate(curDate),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .rdData(rdData), .alarmIrq(alarmIrq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic readCheck(input string req, input logic [1:0] a, input logic [7:0] exp);
    rdAddr = a; #1;
    check(req, rdData, exp);
  endtask

  // Tick at a falling edge; pulse due at the next falling edge, low one after.
  task automatic tickCheck(input string req, input logic exp);
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    check(req, {7'b0, alarmIrq}, {7'b0, exp});
    @(negedge clk);
    check({req, " width"}, {7'b0, alarmIrq}, 8'h00);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual running expected done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R13 reset state
    for (int a = 0; a < 4; a++) readCheck("R13", 2'(a), 8'h00);
    check("R13 irq", {7'b0, alarmIrq}, 8'h00);

    for (int v = 0; v < NVEC; v++) begin
      string tag;
      tag = $sformatf("R%0d vec %0d", VEC[v][11:0], v);
      curSec = VEC[v][44:37]; curMin = VEC[v][36:29];
      curHour = VEC[v][28:21]; curDate = VEC[v][20:13];
      writeReg(2'd0, VEC[v][76:69]);
      writeReg(2'd1, VEC[v][68:61]);
      writeReg(2'd2, VEC[v][60:53]);
      writeReg(2'd3, VEC[v][52:45]);
      tickCheck(tag, VEC[v][12]);
    end

    // R1 readback of full bytes with mask bits
    writeReg(2'd0, 8'hD9); readCheck("R1 sec", 2'd0, 8'hD9);
    writeReg(2'd1, 8'hB4); readCheck("R1 min", 2'd1, 8'hB4);
    writeReg(2'd2, 8'h23); readCheck("R4 hour 23 accepted", 2'd2, 8'h23);
    writeReg(2'd3, 8'h31); readCheck("R5 date bits 4:0 = 11 accepted", 2'd3, 8'h31);

    // R2 seconds 60 rejected
    writeReg(2'd0, 8'h60); readCheck("R2", 2'd0, 8'hD9);
    writeReg(2'd0, 8'h5A); readCheck("R2 value 60", 2'd0, 8'hD9);
    // R3 minutes out of range
    writeReg(2'd1, 8'h7F); readCheck("R3", 2'd1, 8'hB4);
    // R4 hours 24 rejected, also with bit 6 set
    writeReg(2'd2, 8'h24); readCheck("R4", 2'd2, 8'h23);
    writeReg(2'd2, 8'h64); readCheck("R4 bit6", 2'd2, 8'h23);
    // R5 date zero rejected
    writeReg(2'd3, 8'h00); readCheck("R5", 2'd3, 8'h31);
    writeReg(2'd3, 8'h80); readCheck("R5 masked zero", 2'd3, 8'h31);

    // R11 every-second mode but no tick: no pulse
    writeReg(2'd0, 8'h80); writeReg(2'd1, 8'h80);
    writeReg(2'd2, 8'h80); writeReg(2'd3, 8'h81);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check("R11 no tick", {7'b0, alarmIrq}, 8'h00);
    end
    tickCheck("R11 tick", 1'b1);

    // R12 stopped clock suppresses
    clkRun = 0;
    tickCheck("R12", 1'b0);
    clkRun = 1;
    tickCheck("R12 resumed", 1'b1);

    finishRun();
  end
endmodule